// File: doc/BRIEF.md
# Configurable Memory Window Mapper

The mapper sits between a CPU address bus and two shared memories, a flash ROM and a RAM. It recognises three address windows: two 1 KB I/O pages (0x9800–0x9BFF and 0x9C00–0x9FFF) and one 8 KB block (0xA000–0xBFFF). Each window turns the CPU address into a local address, adds a base offset from a configuration register and wraps the sum to the size of the memory it targets. For every access it drives a ROM chip select, a RAM chip select, a RAM write enable, the translated memory address and an access-valid flag.

Each window has its own 2-bit mode: off, ROM, RAM with writes blocked, or RAM with writes allowed. The two I/O pages share one base register, and the block has its own. Both memories answer one clock after the select. The mapper records which source a read went to and returns that source's byte on the next cycle, together with a read-data-valid flag. A read from an off window, or from an address outside every window, returns the last byte seen on the CPU bus with the flag low. Configuration is loaded through a plain write port.

Top module: `mwm_mapper`

## Requirements
- R1: After reset every window is off and both base registers are zero, so no access raises a chip select, `acc_valid` or `rdata_valid`.
- R2: Only addresses 0x9800–0x9BFF (I/O page 0), 0x9C00–0x9FFF (I/O page 1) and 0xA000–0xBFFF (block) can hit a window. Any other address leaves `acc_valid`, `rom_cs`, `ram_cs` and `ram_we` low and `mem_addr` zero.
- R3: On I/O page 0 the local address is the low 10 address bits ORed with 0x1800. On I/O page 1 it is the low 10 bits ORed with 0x1C00. The shared I/O base is added to that local address.
- R4: In the block the local address is the low 13 address bits, and the block base is added to it.
- R5: The sum is taken modulo 2^ROM_AW when the window targets ROM and modulo 2^RAM_AW when it targets RAM. That result appears on `mem_addr` in the same cycle as the access.
- R6: Mode codes are 0 = off, 1 = ROM, 2 = RAM read-only and 3 = RAM read-write. A read in mode 1 raises only `rom_cs`. A read in mode 2 or 3 raises only `ram_cs`. `acc_valid` is high whenever a read or write hits a window that is not off.
- R7: A read from an off window or from outside all windows keeps `acc_valid` low. In the next cycle `cpu_rdata` equals `bus_last_data` and `rdata_valid` is low.
- R8: In the cycle after a read that hit an enabled window, `cpu_rdata` equals `rom_rdata` (for a ROM target) or `ram_rdata` (for a RAM target), and `rdata_valid` is high.
- R9: `ram_we` (with `ram_cs`) rises only for a write to a window in mode 3. A write in modes 0, 1 or 2 leaves RAM unchanged and never raises `rom_cs`.
- R10: A configuration write takes effect from the next cycle, and an access in the same cycle still uses the old settings. The `cfg_sel` codes are: 0 = modes (bits [1:0] page 0, [3:2] page 1, [5:4] block), 1 = I/O base, 2 = block base, 3 = ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | MA_W | Configuration write data |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| bus_last_data | input | 8 | Byte most recently seen on the CPU bus |
| rom_rdata | input | 8 | ROM read data, one cycle after `rom_cs` |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_cs` |
| rom_cs | output | 1 | ROM read select |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| mem_addr | output | MA_W | Translated memory address |
| acc_valid | output | 1 | Access hit an enabled window |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rdata_valid | output | 1 | `cpu_rdata` comes from a mapped memory |

## Verification
A configuration write and a CPU access can land in the same cycle. The bench provokes this by raising `cfg_we` during a block read, during a blocked write and during an I/O-page read. In each case the write changes that window's mode or base, or uses the ignored select code. The expectation for that cycle is computed from the settings held before the write, and the next access is expected to follow the new settings. A write that slipped through in the overlap cycle would show up on `ram_we` and in a later read-back.

// File: rtl/mwm_pkg.sv
package mwm_pkg;

  localparam int NWIN   = 3;
  localparam int CPU_AW = 16;
  localparam int LOC_W  = 13;

  localparam int WIN_IO0 = 0;
  localparam int WIN_IO1 = 1;
  localparam int WIN_BLK = 2;

  typedef enum logic [1:0] {
    MD_OFF    = 2'd0,
    MD_ROM    = 2'd1,
    MD_RAM_RO = 2'd2,
    MD_RAM_RW = 2'd3
  } win_mode_e;

  typedef enum logic [1:0] {
    TG_NONE = 2'd0,
    TG_ROM  = 2'd1,
    TG_RAM  = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    CS_MODES = 2'd0,
    CS_IOB   = 2'd1,
    CS_BLKB  = 2'd2,
    CS_NONE  = 2'd3
  } cfg_sel_e;

  // Number of upper address bits compared for a window
  function automatic int win_match_w(int i);
    return (i == WIN_BLK) ? 3 : 6;
  endfunction

  // Value those upper bits must hold
  function automatic int win_match_val(int i);
    if (i == WIN_IO0) return 'h26;
    if (i == WIN_IO1) return 'h27;
    return 'h5;
  endfunction

  // Mask applied to the low 13 address bits
  function automatic int win_off_mask(int i);
    return (i == WIN_BLK) ? 'h1FFF : 'h03FF;
  endfunction

  // Constant ORed into the local address
  function automatic int win_local_or(int i);
    if (i == WIN_IO0) return 'h1800;
    if (i == WIN_IO1) return 'h1C00;
    return 0;
  endfunction

endpackage

// File: rtl/mwm_cfg_regs.sv
module mwm_cfg_regs
  import mwm_pkg::*;
#(
  parameter int MA_W = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [MA_W-1:0]            cfg_wdata,
  output logic [NWIN-1:0][1:0]       mode_o,
  output logic [MA_W-1:0]            io_base_o,
  output logic [MA_W-1:0]            blk_base_o
);

  logic [NWIN-1:0][1:0] mode_d, mode_q;
  logic [MA_W-1:0]      iob_d, iob_q;
  logic [MA_W-1:0]      blkb_d, blkb_q;

  always_comb begin
    mode_d = mode_q;
    iob_d  = iob_q;
    blkb_d = blkb_q;
    unique case (cfg_sel_e'(cfg_sel))
      CS_MODES: begin
        for (int i = 0; i < NWIN; i++) begin
          mode_d[i] = cfg_wdata[2*i +: 2];
        end
      end
      CS_IOB:  iob_d  = cfg_wdata;
      CS_BLKB: blkb_d = cfg_wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      iob_q  <= '0;
      blkb_q <= '0;
    end else if (cfg_we) begin
      mode_q <= mode_d;
      iob_q  <= iob_d;
      blkb_q <= blkb_d;
    end
  end

  assign mode_o     = mode_q;
  assign io_base_o  = iob_q;
  assign blk_base_o = blkb_q;

endmodule

// File: rtl/mwm_window.sv
module mwm_window
  import mwm_pkg::*;
#(
  parameter int MA_W      = 14,
  parameter int ROM_AW    = 14,
  parameter int RAM_AW    = 11,
  parameter int MATCH_W   = 6,
  parameter int MATCH_VAL = 'h26,
  parameter int OFF_MASK  = 'h3FF,
  parameter int LOCAL_OR  = 'h1800
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [1:0]        mode,
  input  logic [MA_W-1:0]   base,
  output logic              hit,
  output logic [1:0]        tgt,
  output logic [MA_W-1:0]   xaddr
);

  localparam int SUM_W = (MA_W > LOC_W) ? MA_W : LOC_W;

  logic [LOC_W-1:0] loc;
  logic [SUM_W-1:0] sum;

  always_comb begin
    hit = (cpu_addr[CPU_AW-1 -: MATCH_W] == MATCH_W'(MATCH_VAL));
    loc = LOC_W'(LOCAL_OR) | (cpu_addr[LOC_W-1:0] & LOC_W'(OFF_MASK));
    sum = SUM_W'(loc) + SUM_W'(base);
    unique case (win_mode_e'(mode))
      MD_ROM: begin
        tgt   = TG_ROM;
        xaddr = MA_W'(sum[ROM_AW-1:0]);
      end
      MD_RAM_RO, MD_RAM_RW: begin
        tgt   = TG_RAM;
        xaddr = MA_W'(sum[RAM_AW-1:0]);
      end
      default: begin
        tgt   = TG_NONE;
        xaddr = '0;
      end
    endcase
  end

endmodule

// File: rtl/mwm_route.sv
module mwm_route
  import mwm_pkg::*;
#(
  parameter int MA_W = 14
) (
  input  logic                       cpu_rd,
  input  logic                       cpu_wr,
  input  logic [NWIN-1:0]            win_hit,
  input  logic [NWIN-1:0][1:0]       win_tgt,
  input  logic [NWIN-1:0][1:0]       win_mode,
  input  logic [NWIN-1:0][MA_W-1:0]  win_addr,
  output logic                       rom_cs,
  output logic                       ram_cs,
  output logic                       ram_we,
  output logic                       acc_valid,
  output logic [MA_W-1:0]            mem_addr,
  output logic [1:0]                 rd_tgt
);

  tgt_e            sel_tgt;
  win_mode_e       sel_mode;
  logic [MA_W-1:0] sel_addr;
  logic            any_acc;
  logic            wr_ok;

  always_comb begin
    sel_tgt  = TG_NONE;
    sel_mode = MD_OFF;
    sel_addr = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (win_hit[i]) begin
        sel_tgt  = tgt_e'(win_tgt[i]);
        sel_mode = win_mode_e'(win_mode[i]);
        sel_addr = win_addr[i];
      end
    end
    any_acc   = cpu_rd | cpu_wr;
    acc_valid = any_acc && (sel_tgt != TG_NONE);
    wr_ok     = cpu_wr && (sel_tgt == TG_RAM) && (sel_mode == MD_RAM_RW);
    rom_cs    = cpu_rd && (sel_tgt == TG_ROM);
    ram_cs    = (sel_tgt == TG_RAM) && (cpu_rd || wr_ok);
    ram_we    = wr_ok;
    mem_addr  = acc_valid ? sel_addr : '0;
    rd_tgt    = (cpu_rd && acc_valid) ? sel_tgt : TG_NONE;
  end

endmodule

// File: rtl/mwm_rdata_sel.sv
module mwm_rdata_sel
  import mwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [1:0]    rd_tgt,
  input  logic [DW-1:0] bus_last_data,
  input  logic [DW-1:0] rom_rdata,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          rdata_valid
);

  logic [1:0] tgt_d, tgt_q;

  always_comb begin
    tgt_d = tgt_q;
    if (rd_en) tgt_d = rd_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= TG_NONE;
    else        tgt_q <= tgt_d;
  end

  always_comb begin
    unique case (tgt_e'(tgt_q))
      TG_ROM:  cpu_rdata = rom_rdata;
      TG_RAM:  cpu_rdata = ram_rdata;
      default: cpu_rdata = bus_last_data;
    endcase
    rdata_valid = (tgt_q != TG_NONE);
  end

endmodule

// File: rtl/mwm_mapper.sv
module mwm_mapper
  import mwm_pkg::*;
#(
  parameter int ROM_AW = 14,
  parameter int RAM_AW = 11,
  parameter int DW     = 8,
  parameter int MA_W   = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [MA_W-1:0]   cfg_wdata,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DW-1:0]     bus_last_data,
  input  logic [DW-1:0]     rom_rdata,
  input  logic [DW-1:0]     ram_rdata,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic              acc_valid,
  output logic [DW-1:0]     cpu_rdata,
  output logic              rdata_valid
);

  logic [NWIN-1:0][1:0]      mode_w;
  logic [MA_W-1:0]           io_base_w;
  logic [MA_W-1:0]           blk_base_w;
  logic [NWIN-1:0]           win_hit;
  logic [NWIN-1:0][1:0]      win_tgt;
  logic [NWIN-1:0][MA_W-1:0] win_addr;
  logic [1:0]                rd_tgt_w;

  mwm_cfg_regs #(.MA_W(MA_W)) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .mode_o     (mode_w),
    .io_base_o  (io_base_w),
    .blk_base_o (blk_base_w)
  );

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    logic [MA_W-1:0] base_w;
    if (gi == WIN_BLK) begin : g_blk
      assign base_w = blk_base_w;
    end else begin : g_io
      assign base_w = io_base_w;
    end

    mwm_window #(
      .MA_W      (MA_W),
      .ROM_AW    (ROM_AW),
      .RAM_AW    (RAM_AW),
      .MATCH_W   (win_match_w(gi)),
      .MATCH_VAL (win_match_val(gi)),
      .OFF_MASK  (win_off_mask(gi)),
      .LOCAL_OR  (win_local_or(gi))
    ) win_i (
      .cpu_addr (cpu_addr),
      .mode     (mode_w[gi]),
      .base     (base_w),
      .hit      (win_hit[gi]),
      .tgt      (win_tgt[gi]),
      .xaddr    (win_addr[gi])
    );
  end

  mwm_route #(.MA_W(MA_W)) route_i (
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .win_hit   (win_hit),
    .win_tgt   (win_tgt),
    .win_mode  (mode_w),
    .win_addr  (win_addr),
    .rom_cs    (rom_cs),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .acc_valid (acc_valid),
    .mem_addr  (mem_addr),
    .rd_tgt    (rd_tgt_w)
  );

  mwm_rdata_sel #(.DW(DW)) rdsel_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (cpu_rd),
    .rd_tgt        (rd_tgt_w),
    .bus_last_data (bus_last_data),
    .rom_rdata     (rom_rdata),
    .ram_rdata     (ram_rdata),
    .cpu_rdata     (cpu_rdata),
    .rdata_valid   (rdata_valid)
  );

endmodule

// File: rtl/mwm_mapper_chk.sv
module mwm_mapper_chk
  import mwm_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [CPU_AW-1:0]    cpu_addr,
  input logic                 cpu_rd,
  input logic                 cpu_wr,
  input logic [DW-1:0]        bus_last_data,
  input logic                 rom_cs,
  input logic                 ram_cs,
  input logic                 ram_we,
  input logic                 acc_valid,
  input logic [DW-1:0]        cpu_rdata,
  input logic                 rdata_valid,
  input logic [NWIN-1:0][1:0] mode_w
);

  logic in_io0, in_io1, in_blk, in_any;
  assign in_io0 = (cpu_addr[15:10] == 6'h26);
  assign in_io1 = (cpu_addr[15:10] == 6'h27);
  assign in_blk = (cpu_addr[15:13] == 3'h5);
  assign in_any = in_io0 | in_io1 | in_blk;

  // R2: no window outside the three address ranges
  p_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_any |-> !acc_valid && !rom_cs && !ram_cs && !ram_we);

  // R6: at most one memory selected
  p_one_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && ram_cs));

  // R6: a chip select implies a valid access
  p_cs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs || ram_cs) |-> acc_valid);

  // R7: an off block never reports a valid access
  p_off_blk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_blk && (mode_w[WIN_BLK] == 2'd0) |-> !acc_valid);

  // R9: RAM write only on a CPU write with RAM selected
  p_we_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> cpu_wr && ram_cs);

  // R9: ROM is never selected by a pure write
  p_rom_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> cpu_rd);

  // R8: a read hit yields valid data next cycle
  p_rdv_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && acc_valid |=> rdata_valid);

  // R7: a read miss yields bus-held data next cycle
  p_rdv_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !acc_valid |=> !rdata_valid && (cpu_rdata == bus_last_data));

  // R10: modes hold without a configuration write
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mode_w));

endmodule

bind mwm_mapper mwm_mapper_chk #(.DW(DW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .cpu_addr      (cpu_addr),
  .cpu_rd        (cpu_rd),
  .cpu_wr        (cpu_wr),
  .bus_last_data (bus_last_data),
  .rom_cs        (rom_cs),
  .ram_cs        (ram_cs),
  .ram_we        (ram_we),
  .acc_valid     (acc_valid),
  .cpu_rdata     (cpu_rdata),
  .rdata_valid   (rdata_valid),
  .mode_w        (mode_w)
);

// File: tb/mwm_mapper_tb_top.sv
module mwm_mapper_tb_top;

  localparam int ROM_AW = 14;
  localparam int RAM_AW = 11;
  localparam int MA_W   = 14;
  localparam int ROM_SZ = 1 << ROM_AW;
  localparam int RAM_SZ = 1 << RAM_AW;

  logic            clk;
  logic            rst_n;
  logic            cfg_we;
  logic [1:0]      cfg_sel;
  logic [MA_W-1:0] cfg_wdata;
  logic [15:0]     cpu_addr;
  logic            cpu_rd, cpu_wr;
  logic [7:0]      bus_last_data;
  logic [7:0]      rom_rdata, ram_rdata;
  logic            rom_cs, ram_cs, ram_we;
  logic [MA_W-1:0] mem_addr;
  logic            acc_valid;
  logic [7:0]      cpu_rdata;
  logic            rdata_valid;
  logic [7:0]      tb_wdata;

  mwm_mapper #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .bus_last_data(bus_last_data), .rom_rdata(rom_rdata),
    .ram_rdata(ram_rdata), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .ram_we(ram_we), .mem_addr(mem_addr), .acc_valid(acc_valid),
    .cpu_rdata(cpu_rdata), .rdata_valid(rdata_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] rom_fn(int a);
    return 8'(a ^ (a >> 6)) + 8'h11;
  endfunction

  function automatic logic [7:0] ram_init(int a);
    return 8'(a * 7 + 3);
  endfunction

  // memory models: synchronous, one cycle read latency
  logic [7:0] ram_mem [RAM_SZ];
  logic [7:0] shadow  [RAM_SZ];
  initial begin
    for (int i = 0; i < RAM_SZ; i++) begin
      ram_mem[i] = ram_init(i);
      shadow[i]  = ram_init(i);
    end
  end

  always @(posedge clk) begin
    if (rom_cs) rom_rdata <= rom_fn(int'(mem_addr));
    if (ram_cs) begin
      if (ram_we) ram_mem[mem_addr[RAM_AW-1:0]] <= tb_wdata;
      else        ram_rdata <= ram_mem[mem_addr[RAM_AW-1:0]];
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  int tb_mode [3];
  int tb_iob  = 0;
  int tb_blkb = 0;
  int cyc     = 0;

  task automatic ceq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      summary();
    end
  end

  function automatic int win_of(int a);
    if ((a >> 10) == 'h26) return 0;
    if ((a >> 10) == 'h27) return 1;
    if ((a >> 13) == 'h5)  return 2;
    return -1;
  endfunction

  task automatic apply_cfg(int sel, int data);
    case (sel)
      0: for (int i = 0; i < 3; i++) tb_mode[i] = (data >> (2*i)) & 3;
      1: tb_iob  = data & (ROM_SZ - 1);
      2: tb_blkb = data & (ROM_SZ - 1);
      default: ;
    endcase
  endtask

  // one access per cycle; called and returns at a falling edge
  task automatic acc(int a, bit rd, bit wr, int wd, string tag = "",
                     bit do_cfg = 0, int csel = 0, int cdata = 0);
    int w, m, base, loc, e_addr, e_data;
    bit act;
    string t_sel, t_addr, t_dat;
    w    = win_of(a);
    m    = (w < 0) ? 0 : tb_mode[w];
    base = (w == 2) ? tb_blkb : tb_iob;
    if (w == 0)      loc = 'h1800 | (a & 'h3FF);
    else if (w == 1) loc = 'h1C00 | (a & 'h3FF);
    else             loc = a & 'h1FFF;
    act = rd || wr;
    if (!act || m == 0) e_addr = 0;
    else if (m == 1)    e_addr = (loc + base) % ROM_SZ;
    else                e_addr = (loc + base) % RAM_SZ;
    t_sel  = (tag != "") ? tag : (w < 0) ? "R2" : (m == 0) ? "R7" : "R6";
    t_addr = (tag != "") ? tag : (w == 2) ? "R4/R5" : (w < 0) ? "R2" : "R3/R5";
    t_dat  = (tag != "") ? tag : (m == 0) ? "R7" : "R8";

    cpu_addr      = 16'(a);
    cpu_rd        = rd;
    cpu_wr        = wr;
    tb_wdata      = 8'(wd);
    bus_last_data = 8'(a) ^ 8'hA5;
    cfg_we        = do_cfg;
    cfg_sel       = 2'(csel);
    cfg_wdata     = MA_W'(cdata);
    #2;
    ceq(t_sel,  "acc_valid", int'(acc_valid), int'(act && m != 0));
    ceq(t_sel,  "rom_cs",    int'(rom_cs),    int'(rd && m == 1));
    ceq(t_sel,  "ram_cs",    int'(ram_cs),    int'(m >= 2 && (rd || (wr && m == 3))));
    ceq((tag != "") ? tag : "R9", "ram_we", int'(ram_we), int'(wr && m == 3));
    ceq(t_addr, "mem_addr",  int'(mem_addr),  e_addr);
    @(posedge clk);
    if (do_cfg) apply_cfg(csel, cdata);
    if (wr && m == 3) shadow[e_addr] = 8'(wd);
    @(negedge clk);
    if (rd) begin
      if (m == 0)      e_data = int'(8'(a) ^ 8'hA5);
      else if (m == 1) e_data = int'(rom_fn(e_addr));
      else             e_data = int'(shadow[e_addr]);
      ceq(t_dat, "cpu_rdata",   int'(cpu_rdata),   e_data);
      ceq(t_dat, "rdata_valid", int'(rdata_valid), int'(m != 0));
    end
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
    cfg_we = 1'b0;
  endtask

  task automatic cfg(int sel, int data);
    acc(0, 0, 0, 0, "R10", 1, sel, data);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) tb_mode[i] = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    cpu_addr = 16'hA000; cpu_rd = 1'b1; cpu_wr = 1'b0;
    bus_last_data = 8'h3C; tb_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: quiet while held in reset
    ceq("R1", "acc_valid in reset",   int'(acc_valid),   0);
    ceq("R1", "rom_cs in reset",      int'(rom_cs),      0);
    ceq("R1", "rdata_valid in reset", int'(rdata_valid), 0);
    cpu_rd = 1'b0;
    rst_n  = 1'b1;
    @(negedge clk);
    // R1: all windows off after reset
    acc('h9800, 1, 0, 0, "R1");
    acc('h9FFF, 1, 0, 0, "R1");
    acc('hA000, 1, 1, 0, "R1");
    acc('hBFFF, 1, 0, 0, "R1");

    // exhaustive page sweeps, strided block sweep, all uniform modes
    for (int b = 0; b < 2; b++) begin
      cfg(1, (b == 0) ? 0 : 'h2A57);
      cfg(2, (b == 0) ? 0 : 'h3E01);
      for (int m = 0; m < 4; m++) begin
        cfg(0, (m << 4) | (m << 2) | m);
        for (int o = 0; o < 1024; o++) begin
          acc('h9800 + o, 1, 0, 0);
          acc('h9C00 + o, 1, 0, 0);
        end
        for (int a = 'hA000; a < 'hC000; a += 5) acc(a, 1, 0, 0);
      end
    end

    // mixed modes: page0 ROM, page1 RAM-RW, block RAM-RO
    cfg(0, (2 << 4) | (3 << 2) | 1);
    for (int a = 'h9800; a < 'hC000; a += 17) acc(a, 1, 0, 0);

    // R2: whole address space, windows all RAM-RW
    cfg(0, 'h3F);
    for (int a = 0; a < 'h10000; a += 61) acc(a, 1, 0, 0);

    // R9: writes in RW block, blocked in RO page, ROM page, off
    cfg(0, (3 << 4) | (1 << 2) | 2);
    for (int k = 0; k < 20; k++) acc('hA000 + k * 397, 0, 1, 'h40 + k);
    for (int k = 0; k < 20; k++) acc('hA000 + k * 397, 1, 0, 0, "R9");
    for (int k = 0; k < 12; k++) acc('h9800 + k * 83, 0, 1, 'hEE, "R9");
    for (int k = 0; k < 12; k++) acc('h9800 + k * 83, 1, 0, 0, "R9");
    for (int k = 0; k < 12; k++) acc('h9C00 + k * 83, 0, 1, 'hEE, "R9");
    for (int k = 0; k < 12; k++) acc('h9C00 + k * 83, 1, 0, 0, "R9");
    cfg(0, (0 << 4) | (1 << 2) | 2);
    acc('hA7F3, 0, 1, 'h99, "R9");
    cfg(0, (3 << 4) | (1 << 2) | 2);
    acc('hA7F3, 1, 0, 0, "R9");

    // R10: configuration write in the same cycle as an access
    cfg(0, (1 << 4));
    acc('hA123, 1, 0, 0, "R10", 1, 0, (3 << 4));
    acc('hA123, 1, 0, 0, "R10");
    acc('hA2B4, 1, 0, 0, "R10", 1, 3, 0);
    acc('hA2B4, 1, 0, 0, "R10");
    acc('hA2B4, 1, 0, 0, "R10", 1, 2, 'h0155);
    acc('hA2B4, 1, 0, 0, "R10");
    cfg(0, (2 << 4) | 1);
    acc('hB456, 0, 1, 'h77, "R10", 1, 0, (3 << 4) | 1);
    acc('hB456, 1, 0, 0, "R10");
    acc('h9855, 1, 0, 0, "R10", 1, 1, 'h0100);
    acc('h9855, 1, 0, 0, "R10");

    summary();
  end

endmodule